// File: doc/BRIEF.md
# Control Register Bank with Auto-Increment

This block is the byte-wide control register file that sits behind a serial-bus slave front end. The front end decodes the bus protocol. It then hands this block a start strobe carrying a sub-address, followed by one strobe per received data byte. The bank keeps a write pointer. Each data byte is stored at the pointer. After each byte the pointer moves on to the next address, but only while the increment-disable bit held in the bank's own mode register is clear.

The bank holds eight level registers, an offset/contrast register, a global control register, a mode register, a clamp/bandwidth register and a self-clearing soft-reset register. It drives the decoded fields out to the rest of the device. A combinational read port returns the stored value at any address. A soft reset restores every register except the soft-reset register itself. It leaves the pointer alone, so the bus transaction that is underway carries on.

Top module: `ctl_regbank`

## Requirements
- R1: After `rst` every level register (00h to 07h) reads 00h, 08h reads 00h, 09h reads 00h, 0Ah reads 00h (auto-increment on), 0Bh reads 04h and 0Fh reads 00h. The decoded outputs match these values.
- R2: `start_i` loads the pointer with `sub_addr_i`. A byte strobe in the same cycle as `start_i` is dropped.
- R3: While bit 0 of 0Ah is 0, successive bytes are stored at successive addresses. Whether the pointer advances is decided from the mode value held before the byte arrives, so the byte that changes the mode still obeys the old mode.
- R4: While bit 0 of 0Ah is 1, every byte of a transaction rewrites the register at the starting sub-address.
- R5: In 08h, bits 2..0 drive `offset_o` and bits 4..3 drive `contrast_o`. In 09h, bit 0 drives `blank_o`, bit 1 `sleep_o`, bit 3 `half_range_o` and bit 4 `mix_o`. In 0Bh, bits 2..0 drive `bw_o` and bit 3 drives `clamp_neg_o` (1 = negative-going clamp). Bytes 00h to 07h drive `level_o[8*i+7:8*i]` for register i.
- R6: Reserved bits and must-be-zero bits are not stored and always read 0. These are 08h bits 7..5; 09h bits 7..5 and bit 2; 0Ah bits 7..1; 0Bh bits 7..4; and 0Fh bits 7..1.
- R7: Addresses 0Ch to 0Eh and 10h to FFh ignore writes and read 00h.
- R8: After a byte is stored at 0Fh the pointer parks at 10h and stays there until the next start. A start beyond 0Fh never advances the pointer. Parked or out-of-range bytes change no register.
- R9: Writing 1 to bit 0 of 0Fh makes 0Fh read 1 for exactly one cycle. At the next edge every other register returns to its R1 value and the bit clears. A byte strobed in that completion cycle is dropped.
- R10: The soft reset does not move the pointer. A byte sent without a new start after the reset completes lands where the pointer was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transaction start strobe |
| sub_addr_i | input | 8 | Sub-address loaded on start |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| rd_addr_i | input | 8 | Read-back address |
| rd_data_o | output | 8 | Read-back data (combinational) |
| level_o | output | 64 | Eight level registers, register i in bits 8*i+7..8*i |
| offset_o | output | 3 | Video offset code |
| contrast_o | output | 2 | Overlay contrast code |
| blank_o | output | 1 | Blank output |
| sleep_o | output | 1 | Power-save request |
| half_range_o | output | 1 | Halve range of outputs 1 to 3 |
| mix_o | output | 1 | Mix half of output 4 into outputs 1 to 3 |
| clamp_neg_o | output | 1 | Clamp polarity, 1 = negative-going |
| bw_o | output | 3 | Bandwidth code |

## Verification
The hardest case to reach from the ports is showing that the soft reset leaves the pointer untouched. The reset register is the last address, so with auto-increment on the pointer is already parked past it, and a reset there would look the same whether or not the pointer moved. The stimulus first disables auto-increment so the pointer holds at 0Fh. It then fires the soft reset, which re-enables increment. A second byte of 01h is then sent without a new start: seeing the reset bit set again proves the pointer stayed put. A further 01h sent in the completion cycle must be dropped. Random transactions follow and are compared against a byte model in the bench; they include mode changes in the middle of a stream.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int LVL_CNT = 8;
    localparam int LVL_IW  = $clog2(LVL_CNT);

    localparam logic [AW-1:0] A_OFSCON = 8'h08;
    localparam logic [AW-1:0] A_GLOB   = 8'h09;
    localparam logic [AW-1:0] A_MODE   = 8'h0A;
    localparam logic [AW-1:0] A_CLBW   = 8'h0B;
    localparam logic [AW-1:0] A_SRST   = 8'h0F;
    localparam logic [AW-1:0] A_LAST   = A_SRST;
    localparam logic [AW-1:0] A_PARK   = A_LAST + 8'd1;

    localparam logic [2:0] BW_DEFAULT = 3'b100;

    typedef struct packed {
        logic [1:0] contrast;
        logic [2:0] offset;
    } ofscon_t;

    typedef struct packed {
        logic mix;
        logic half;
        logic sleep;
        logic blank;
    } glob_t;

    typedef struct packed {
        logic       clamp_neg;
        logic [2:0] bw;
    } clbw_t;

    typedef struct packed {
        ofscon_t oc;
        glob_t   gl;
        logic    inc_off;
        clbw_t   cb;
        logic    srst;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '{
        oc:      '0,
        gl:      '0,
        inc_off: 1'b0,
        cb:      '{clamp_neg: 1'b0, bw: BW_DEFAULT},
        srst:    1'b0
    };

    function automatic logic is_level(input logic [AW-1:0] a);
        return a < AW'(LVL_CNT);
    endfunction

    function automatic logic [DW-1:0] pack_oc(input ofscon_t v);
        return {3'b000, v.contrast, v.offset};
    endfunction

    function automatic logic [DW-1:0] pack_gl(input glob_t v);
        return {3'b000, v.mix, v.half, 1'b0, v.sleep, v.blank};
    endfunction

    function automatic logic [DW-1:0] pack_cb(input clbw_t v);
        return {4'b0000, v.clamp_neg, v.bw};
    endfunction

endpackage

// File: rtl/ctl_regbank_ptr.sv
module ctl_regbank_ptr
    import ctl_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] sub_addr_i,
    input  logic          byte_vld_i,
    input  logic          inc_en_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o
);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= A_PARK;
        end else if (start_i) begin
            ptr_q <= sub_addr_i;
        end else if (byte_vld_i && inc_en_i && (ptr_q <= A_LAST)) begin
            ptr_q <= ptr_q + 8'd1;
        end
    end

    assign wr_en_o   = byte_vld_i && !start_i;
    assign wr_addr_o = ptr_q;

    assert_start_loads_ptr_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (ptr_q == $past(sub_addr_i)));

    assert_ptr_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !inc_en_i) |=> $stable(ptr_q));

    assert_ptr_parked_R8: assert property (@(posedge clk) disable iff (rst)
        (!start_i && (ptr_q > A_LAST)) |=> $stable(ptr_q));

endmodule

// File: rtl/ctl_regbank_store.sv
module ctl_regbank_store
    import ctl_regbank_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic [AW-1:0]               wr_addr_i,
    input  logic [DW-1:0]               wr_data_i,
    output logic [LVL_CNT-1:0][DW-1:0]  lvl_o,
    output ctl_t                        ctl_o
);

    ctl_t ctl_q;
    logic wipe;

    assign wipe = rst || ctl_q.srst;

    for (genvar i = 0; i < LVL_CNT; i++) begin : g_lvl
        logic [DW-1:0] lvl_q;
        always_ff @(posedge clk) begin
            if (wipe) begin
                lvl_q <= '0;
            end else if (wr_en_i && (wr_addr_i == AW'(i))) begin
                lvl_q <= wr_data_i;
            end
        end
        assign lvl_o[i] = lvl_q;
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            ctl_q <= CTL_DEFAULT;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                A_OFSCON: begin
                    ctl_q.oc.contrast <= wr_data_i[4:3];
                    ctl_q.oc.offset   <= wr_data_i[2:0];
                end
                A_GLOB: begin
                    ctl_q.gl.mix   <= wr_data_i[4];
                    ctl_q.gl.half  <= wr_data_i[3];
                    ctl_q.gl.sleep <= wr_data_i[1];
                    ctl_q.gl.blank <= wr_data_i[0];
                end
                A_MODE:  ctl_q.inc_off <= wr_data_i[0];
                A_CLBW: begin
                    ctl_q.cb.clamp_neg <= wr_data_i[3];
                    ctl_q.cb.bw        <= wr_data_i[2:0];
                end
                A_SRST:  ctl_q.srst <= wr_data_i[0];
                default: ;
            endcase
        end
    end

    assign ctl_o = ctl_q;

    assert_srst_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_q.srst |=> !ctl_q.srst);

    assert_srst_defaults_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_q.srst |=> ((ctl_q == CTL_DEFAULT) && (lvl_o == '0)));

endmodule

// File: rtl/ctl_regbank_rdmux.sv
module ctl_regbank_rdmux
    import ctl_regbank_pkg::*;
(
    input  logic [AW-1:0]               rd_addr_i,
    input  logic [LVL_CNT-1:0][DW-1:0]  lvl_i,
    input  ctl_t                        ctl_i,
    output logic [DW-1:0]               rd_data_o
);

    always_comb begin
        rd_data_o = '0;
        if (is_level(rd_addr_i)) begin
            rd_data_o = lvl_i[rd_addr_i[LVL_IW-1:0]];
        end else begin
            case (rd_addr_i)
                A_OFSCON: rd_data_o = pack_oc(ctl_i.oc);
                A_GLOB:   rd_data_o = pack_gl(ctl_i.gl);
                A_MODE:   rd_data_o = {7'b0, ctl_i.inc_off};
                A_CLBW:   rd_data_o = pack_cb(ctl_i.cb);
                A_SRST:   rd_data_o = {7'b0, ctl_i.srst};
                default:  rd_data_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import ctl_regbank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [7:0]            sub_addr_i,
    input  logic                  byte_vld_i,
    input  logic [7:0]            byte_i,
    input  logic [7:0]            rd_addr_i,
    output logic [7:0]            rd_data_o,
    output logic [LVL_CNT*DW-1:0] level_o,
    output logic [2:0]            offset_o,
    output logic [1:0]            contrast_o,
    output logic                  blank_o,
    output logic                  sleep_o,
    output logic                  half_range_o,
    output logic                  mix_o,
    output logic                  clamp_neg_o,
    output logic [2:0]            bw_o
);

    logic                       wr_en;
    logic [AW-1:0]              wr_addr;
    logic [LVL_CNT-1:0][DW-1:0] lvl;
    ctl_t                       ctl;

    ctl_regbank_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .sub_addr_i (sub_addr_i),
        .byte_vld_i (byte_vld_i),
        .inc_en_i   (!ctl.inc_off),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr)
    );

    ctl_regbank_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (byte_i),
        .lvl_o     (lvl),
        .ctl_o     (ctl)
    );

    ctl_regbank_rdmux u_rdmux (
        .rd_addr_i (rd_addr_i),
        .lvl_i     (lvl),
        .ctl_i     (ctl),
        .rd_data_o (rd_data_o)
    );

    assign level_o      = lvl;
    assign offset_o     = ctl.oc.offset;
    assign contrast_o   = ctl.oc.contrast;
    assign blank_o      = ctl.gl.blank;
    assign sleep_o      = ctl.gl.sleep;
    assign half_range_o = ctl.gl.half;
    assign mix_o        = ctl.gl.mix;
    assign clamp_neg_o  = ctl.cb.clamp_neg;
    assign bw_o         = ctl.cb.bw;

    assert_glob_rsv_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_i == A_GLOB) |-> ((rd_data_o[7:5] == 3'b000) && !rd_data_o[2]));

    assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_i > A_LAST) |-> (rd_data_o == 8'h00));

    assert_mode_off_blocks_other_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc_off && !start_i && !ctl.srst) |=> $stable(ctl.inc_off) || $past(wr_addr == A_MODE));

endmodule

// File: tb/ctl_regbank_tb_top.sv
module ctl_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  sub_addr_i = '0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [7:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic [63:0] level_o;
    logic [2:0]  offset_o;
    logic [1:0]  contrast_o;
    logic        blank_o, sleep_o, half_range_o, mix_o, clamp_neg_o;
    logic [2:0]  bw_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] exp_m [0:15];
    int mptr;

    always #2 clk = ~clk;

    ctl_regbank dut_i (.*);

    function automatic logic [7:0] mask_fn(input int a, input logic [7:0] d);
        case (a)
            0, 1, 2, 3, 4, 5, 6, 7: return d;
            8:  return d & 8'h1F;
            9:  return d & 8'h1B;
            10: return d & 8'h01;
            11: return d & 8'h0F;
            15: return d & 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        rd_addr_i = a;
        #1;
        v = rd_data_o;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic do_start(input logic [7:0] a);
        @(negedge clk);
        start_i = 1'b1; sub_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk);
        byte_vld_i = 1'b1; byte_i = d;
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic set_defaults();
        for (int i = 0; i < 16; i++) exp_m[i] = 8'h00;
        exp_m[11] = 8'h04;
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < 16; i++) chk_rd(req, 8'(i), exp_m[i]);
        for (int i = 0; i < 8; i++) chk({req, " level_o"}, level_o[i*8 +: 8], exp_m[i]);
        chk({req, " ofs/con ports"}, {3'b0, contrast_o, offset_o}, exp_m[8]);
        chk({req, " global ports"}, {3'b0, mix_o, half_range_o, 1'b0, sleep_o, blank_o}, exp_m[9]);
        chk({req, " clamp/bw ports"}, {4'b0, clamp_neg_o, bw_o}, exp_m[11]);
    endtask

    task automatic model_byte(input logic [7:0] d);
        logic inc_on;
        inc_on = (exp_m[10][0] == 1'b0);
        if (mptr < 16) exp_m[mptr] = mask_fn(mptr, d);
        if (inc_on && mptr <= 15) mptr++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        set_defaults();
        chk_all("R1 reset");

        // R2 byte coincident with start is dropped, pointer loaded
        @(negedge clk);
        start_i = 1'b1; sub_addr_i = 8'h01; byte_vld_i = 1'b1; byte_i = 8'hAA;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
        chk_rd("R2 dropped", 8'h01, 8'h00);
        do_byte(8'h55);
        chk_rd("R2 ptr loaded", 8'h01, 8'h55);

        // R3 consecutive addresses
        do_start(8'h02);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
        chk_rd("R3 a2", 8'h02, 8'h11);
        chk_rd("R3 a3", 8'h03, 8'h22);
        chk_rd("R3 a4", 8'h04, 8'h33);

        // R3 old-mode decision then R4 repeat writes
        do_start(8'h0A);
        do_byte(8'h01);
        do_byte(8'h05);
        chk_rd("R3 mode byte advanced", 8'h0B, 8'h05);
        do_byte(8'h07);
        chk_rd("R4 rewrite same", 8'h0B, 8'h07);
        do_start(8'h05);
        do_byte(8'h9A); do_byte(8'h9B);
        chk_rd("R4 start reg", 8'h05, 8'h9B);
        chk_rd("R4 next untouched", 8'h06, 8'h00);
        do_start(8'h0A);
        do_byte(8'h00);
        chk_rd("R4 mode cleared", 8'h0A, 8'h00);

        // R5 / R6 field layout and reserved bits
        do_start(8'h08);
        do_byte(8'hFF); do_byte(8'hFF); do_byte(8'hFE); do_byte(8'hFF);
        chk_rd("R6 08h", 8'h08, 8'h1F);
        chk_rd("R6 09h", 8'h09, 8'h1B);
        chk_rd("R6 0Ah", 8'h0A, 8'h00);
        chk_rd("R6 0Bh", 8'h0B, 8'h0F);
        chk("R5 offset", {5'b0, offset_o}, 8'h07);
        chk("R5 contrast", {6'b0, contrast_o}, 8'h03);
        chk("R5 global", {4'b0, mix_o, half_range_o, sleep_o, blank_o}, 8'h0F);
        chk("R5 clamp/bw", {4'b0, clamp_neg_o, bw_o}, 8'h0F);
        chk("R5 level1", level_o[15:8], 8'h55);

        // R7 / R8 unmapped and parking
        do_start(8'h0C);
        do_byte(8'h77);
        chk_rd("R7 0Ch", 8'h0C, 8'h00);
        do_start(8'h0E);
        do_byte(8'h33); do_byte(8'h00); do_byte(8'h44); do_byte(8'h66);
        chk_rd("R7 0Eh", 8'h0E, 8'h00);
        chk_rd("R8 no wrap a0", 8'h00, 8'h00);
        chk_rd("R8 a1 kept", 8'h01, 8'h55);
        chk_rd("R7 10h", 8'h10, 8'h00);
        do_start(8'h80);
        do_byte(8'h12); do_byte(8'h13);
        chk_rd("R7 80h", 8'h80, 8'h00);
        chk_rd("R8 high start no wrap", 8'h00, 8'h00);

        // R9 / R10 soft reset, pointer retained
        do_start(8'h0A);
        do_byte(8'h01);
        do_start(8'h0F);
        do_byte(8'h01);
        chk_rd("R9 bit set one cycle", 8'h0F, 8'h01);
        @(negedge clk);
        set_defaults();
        chk_all("R9 defaults");
        do_byte(8'h01);
        chk_rd("R10 pointer kept", 8'h0F, 8'h01);
        byte_vld_i = 1'b1; byte_i = 8'h01;
        @(negedge clk);
        byte_vld_i = 1'b0;
        chk_rd("R9 completion byte dropped", 8'h0F, 8'h00);
        chk_rd("R9 bw default", 8'h0B, 8'h04);

        // Random transactions against the byte model
        set_defaults();
        for (int t = 0; t < 300; t++) begin
            int nb;
            logic [7:0] sa;
            sa = 8'($urandom % 20);
            if (($urandom % 10) == 0) sa = 8'($urandom);
            do_start(sa);
            mptr = int'(sa);
            nb = 1 + int'($urandom % 4);
            for (int b = 0; b < nb; b++) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (mptr == 15) d[0] = 1'b0;
                if (($urandom % 4) == 0 && mptr == 10) d = 8'($urandom % 2);
                do_byte(d);
                model_byte(d);
            end
            chk_all("R3 R4 R5 R6 random");
            begin
                logic [7:0] ua;
                ua = 8'h10 + 8'($urandom % 8'hF0);
                chk_rd("R7 random unmapped", ua, 8'h00);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule